// File: doc/BRIEF.md
# Address Match Breakpoint Trigger

This block holds the comparison side of a hart's hardware breakpoint slots. Every slot receives a control word and a compare word from the trigger register bank. Each cycle the block checks the current instruction fetch address and the current load or store address against every armed slot. The check is gated by the access kinds the slot enables and by the privilege level the hart is running at. A match becomes a breakpoint request before the matched instruction or access takes effect.

Two control layouts are understood. The legacy layout has user, supervisor and machine enables and never fires while the hart is virtualised. The extended layout adds separate enables for virtual user and virtual supervisor mode; these take the place of the plain enables when the virtualisation flag is set. Data matches work on byte ranges. A trigger covers a window that starts at its compare address, and a hit is any overlap between that window and the bytes of the access. The requests from all slots are merged into one registered pulse that carries the index of the lowest-numbered slot that matched.

Top module: `addr_trigger_match`

## Requirements
- R1: A slot can fire only when at least one privilege enable is set (bits 3, 4 or 6, plus bits 23 or 24 for the extended layout) and at least one of load (bit 0), store (bit 1) or execute (bit 2) is set.
- R2: An execute match needs fetch_valid high, the execute bit set and fetch_pc exactly equal to the slot's compare word.
- R3: A load access can match only a slot whose load bit is set, and a store access only a slot whose store bit is set.
- R4: With virt low, the enable used is bit 3 plus the privilege code (user 0 → bit 3, supervisor 1 → bit 4, machine 3 → bit 6). A slot fires only if that bit is set.
- R5: With virt high, an extended-layout slot uses bit 23 plus the privilege code (virtual user 0 → bit 23, virtual supervisor 1 → bit 24). Privilege code 3 under virt never fires.
- R6: A legacy-layout slot never fires while virt is high.
- R7: The layout is taken from the top four bits of the control word: 2 selects legacy, 6 selects extended, and any other value never fires.
- R8: The window size code is bits 17:16 for legacy (with bits 22:21 as upper code bits only when XLEN is 64) and bits 19:16 for extended. Code 1 gives 1 byte, 2 gives 2, 3 gives 4 and 5 gives 8. Code 0 and every other code give an 8-byte window.
- R9: A data access of 2^data_size bytes at data_addr hits when any of its bytes falls inside the window [compare, compare + window).
- R10: brk_req is high for the one cycle after the edge that samples a matching input set, and low otherwise. brk_slot then gives the lowest-numbered matching slot, and it is 0 when brk_req is low. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_flat | input | NUM_SLOTS*XLEN | Control words, slot i at bits [i*XLEN +: XLEN] |
| cmp_flat | input | NUM_SLOTS*XLEN | Compare words, slot i at bits [i*XLEN +: XLEN] |
| fetch_valid | input | 1 | An instruction fetch is presented this cycle |
| fetch_pc | input | XLEN | Address of the fetched instruction |
| ld_en | input | 1 | A load is presented this cycle |
| st_en | input | 1 | A store is presented this cycle |
| data_addr | input | XLEN | First byte address of the data access |
| data_size | input | 2 | Log2 of the access length in bytes |
| priv | input | 2 | Current privilege code (0 user, 1 supervisor, 3 machine) |
| virt | input | 1 | Hart runs in virtualised mode |
| brk_req | output | 1 | Breakpoint exception request |
| brk_slot | output | $clog2(NUM_SLOTS) | Lowest slot that matched |

## Verification
Every match result is registered once, so brk_req and brk_slot answer the inputs presented before the next rising edge. The bench drives each input set on a falling edge and samples the outputs a quarter period after the following rising edge. Each comparison therefore sees exactly the result of the one input set that came before it. Idle cycles between stimuli show that a request lasts only one cycle, and directed cases at the window edges, under each privilege level and with virt on and off are mixed with seeded random control words and near-miss addresses.

// File: rtl/atm_pkg.sv
package atm_pkg;

    localparam logic [3:0] LAYOUT_LEGACY = 4'd2;
    localparam logic [3:0] LAYOUT_EXT    = 4'd6;

    // Decoded window length in bytes for a size code; unsupported codes widen to 8.
    function automatic logic [3:0] win_bytes(input logic [3:0] code);
        case (code)
            4'd1:    win_bytes = 4'd1;
            4'd2:    win_bytes = 4'd2;
            4'd3:    win_bytes = 4'd4;
            4'd5:    win_bytes = 4'd8;
            default: win_bytes = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/atm_slot.sv
module atm_slot #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] ctrl,
    input  logic [XLEN-1:0] cmp,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            ld_en,
    input  logic            st_en,
    input  logic [XLEN-1:0] data_addr,
    input  logic [1:0]      data_size,
    input  logic [1:0]      priv,
    input  logic            virt,
    output logic            hit
);
    import atm_pkg::*;

    localparam int AW = XLEN + 1;

    logic [3:0]    layout;
    logic          is_legacy, is_ext;
    logic          mode_any, rwx_any, armed, priv_ok;
    logic [1:0]    size_hi;
    logic [3:0]    size_code;
    logic [AW-1:0] win_lo, win_hi, acc_lo, acc_hi;
    logic          overlap, exec_hit, data_hit;

    always_comb begin
        layout    = ctrl[XLEN-1 -: 4];
        is_legacy = (layout == LAYOUT_LEGACY);
        is_ext    = (layout == LAYOUT_EXT);

        mode_any = ctrl[3] | ctrl[4] | ctrl[6] | (is_ext & (ctrl[23] | ctrl[24]));
        rwx_any  = |ctrl[2:0];
        armed    = (is_legacy | is_ext) & mode_any & rwx_any;

        if (virt) begin
            priv_ok = is_ext & (priv != 2'd3) & ctrl[23 + 32'(priv)];
        end else begin
            priv_ok = ctrl[3 + 32'(priv)];
        end

        size_hi   = (XLEN == 64) ? ctrl[22:21] : 2'b00;
        size_code = is_ext ? ctrl[19:16] : {size_hi, ctrl[17:16]};

        win_lo  = {1'b0, cmp};
        win_hi  = win_lo + AW'(win_bytes(size_code));
        acc_lo  = {1'b0, data_addr};
        acc_hi  = acc_lo + (AW'(1) << data_size);
        overlap = (acc_lo < win_hi) && (win_lo < acc_hi);

        exec_hit = ctrl[2] & fetch_valid & (fetch_pc == cmp);
        data_hit = ((ctrl[0] & ld_en) | (ctrl[1] & st_en)) & overlap;

        hit = armed & priv_ok & (exec_hit | data_hit);
    end

    p_unarmed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|ctrl[2:0])) |-> !hit);
    p_legacy_virt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (virt && ctrl[XLEN-1 -: 4] == LAYOUT_LEGACY) |-> !hit);
    p_unknown_layout_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[XLEN-1 -: 4] != LAYOUT_LEGACY && ctrl[XLEN-1 -: 4] != LAYOUT_EXT) |-> !hit);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !ld_en && !st_en) |-> !hit);

endmodule

// File: rtl/atm_first_hit.sv
module atm_first_hit #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/addr_trigger_match.sv
module addr_trigger_match #(
    parameter int NUM_SLOTS = 4,
    parameter int XLEN      = 32,
    localparam int IW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS*XLEN-1:0] ctrl_flat,
    input  logic [NUM_SLOTS*XLEN-1:0] cmp_flat,
    input  logic                      fetch_valid,
    input  logic [XLEN-1:0]           fetch_pc,
    input  logic                      ld_en,
    input  logic                      st_en,
    input  logic [XLEN-1:0]           data_addr,
    input  logic [1:0]                data_size,
    input  logic [1:0]                priv,
    input  logic                      virt,
    output logic                      brk_req,
    output logic [IW-1:0]             brk_slot
);
    typedef struct packed {
        logic          req;
        logic [IW-1:0] slot;
    } brk_state_t;

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 any_hit;
    logic [IW-1:0]        first_idx;
    brk_state_t           st_d, st_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        atm_slot #(.XLEN(XLEN)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl        (ctrl_flat[g*XLEN +: XLEN]),
            .cmp         (cmp_flat[g*XLEN +: XLEN]),
            .fetch_valid (fetch_valid),
            .fetch_pc    (fetch_pc),
            .ld_en       (ld_en),
            .st_en       (st_en),
            .data_addr   (data_addr),
            .data_size   (data_size),
            .priv        (priv),
            .virt        (virt),
            .hit         (slot_hit[g])
        );
    end

    atm_first_hit #(.N(NUM_SLOTS), .IW(IW)) u_first (
        .req (slot_hit),
        .any (any_hit),
        .idx (first_idx)
    );

    always_comb begin
        st_d.req  = any_hit;
        st_d.slot = any_hit ? first_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign brk_req  = st_q.req;
    assign brk_slot = st_q.slot;

    p_hit_raises_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_hit) |=> brk_req);
    p_no_hit_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_hit == '0) |=> (!brk_req && brk_slot == '0));
    p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !ld_en && !st_en) |=> !brk_req);

endmodule

// File: tb/addr_trigger_match_bench.sv
module addr_trigger_match_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int XL = 32;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [XL-1:0] ctl [NS];
    logic [XL-1:0] cmpv [NS];
    logic [NS*XL-1:0] ctrl_flat, cmp_flat;
    logic fetch_valid = 0, ld_en = 0, st_en = 0, virt = 0;
    logic [XL-1:0] fetch_pc = '0, data_addr = '0;
    logic [1:0] data_size = '0, priv = 2'd3;
    logic brk_req;
    logic [IW-1:0] brk_slot;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            ctrl_flat[i*XL +: XL] = ctl[i];
            cmp_flat[i*XL +: XL]  = cmpv[i];
        end
    end

    addr_trigger_match #(.NUM_SLOTS(NS), .XLEN(XL)) u_addr_trigger_match (
        .clk(clk), .rst_n(rst_n), .ctrl_flat(ctrl_flat), .cmp_flat(cmp_flat),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .ld_en(ld_en), .st_en(st_en),
        .data_addr(data_addr), .data_size(data_size), .priv(priv), .virt(virt),
        .brk_req(brk_req), .brk_slot(brk_slot)
    );

    // typ, {u,s,m}, {vu,vs}, {ex,st,ld}, size code
    function automatic logic [XL-1:0] mk(input logic [3:0] typ, input logic [2:0] usm,
                                         input logic [1:0] vuvs, input logic [2:0] esl,
                                         input logic [3:0] code);
        logic [XL-1:0] c = '0;
        c[31:28] = typ;
        c[3] = usm[2]; c[4] = usm[1]; c[6] = usm[0];
        c[23] = vuvs[1]; c[24] = vuvs[0];
        c[2:0] = esl;
        if (typ == 4'd6) c[19:16] = code; else c[17:16] = code[1:0];
        return c;
    endfunction

    function automatic bit model_slot(input int s, input bit fv, input logic [XL-1:0] pc,
                                      input bit ld, input bit st, input logic [XL-1:0] a,
                                      input logic [1:0] sz, input logic [1:0] pr, input bit vt);
        logic [XL-1:0] c = ctl[s];
        logic [3:0] t = c[31:28];
        bit en, any_mode, dmatch;
        logic [3:0] code;
        int wl;
        logic [63:0] lo, b;
        if (t != 4'd2 && t != 4'd6) return 0;
        any_mode = c[3] | c[4] | c[6] | ((t == 4'd6) & (c[23] | c[24]));
        if (!any_mode || c[2:0] == 3'b000) return 0;
        if (vt) begin
            if (t == 4'd2) return 0;
            en = (pr == 2'd0) ? c[23] : (pr == 2'd1) ? c[24] : 1'b0;
        end else begin
            en = (pr == 2'd0) ? c[3] : (pr == 2'd1) ? c[4] : (pr == 2'd3) ? c[6] : 1'b0;
        end
        if (!en) return 0;
        if (c[2] && fv && pc == cmpv[s]) return 1;
        code = (t == 4'd6) ? c[19:16] : {2'b00, c[17:16]};
        case (code)
            4'd1: wl = 1; 4'd2: wl = 2; 4'd3: wl = 4; default: wl = 8;
        endcase
        dmatch = 0;
        lo = {32'd0, cmpv[s]};
        for (int k = 0; k < (1 << sz); k++) begin
            b = {32'd0, a} + 64'(k);
            if (b >= lo && b < lo + 64'(wl)) dmatch = 1;
        end
        return ((c[0] && ld) || (c[1] && st)) && dmatch;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input bit fv, input logic [XL-1:0] pc, input bit ld, input bit st,
                         input logic [XL-1:0] a, input logic [1:0] sz,
                         input logic [1:0] pr, input bit vt,
                         input bit exp_req, input int exp_slot, input string tag);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; ld_en = ld; st_en = st;
        data_addr = a; data_size = sz; priv = pr; virt = vt;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(brk_req == exp_req, {tag, " req"}, brk_req, exp_req);
        chk(int'(brk_slot) == (exp_req ? exp_slot : 0), {tag, " slot"}, brk_slot,
            exp_req ? exp_slot : 0);
    endtask

    task automatic idle();
        @(negedge clk);
        fetch_valid = 0; ld_en = 0; st_en = 0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(brk_req == 0, "R10 pulse ends after idle", brk_req, 0);
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NS; i++) begin ctl[i] = '0; cmpv[i] = '0; end
    endtask

    initial begin
        #(CLK_PERIOD*50000);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_slots();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk(brk_req == 0, "R10 reset req", brk_req, 0);
        chk(brk_slot == 0, "R10 reset slot", brk_slot, 0);
        @(negedge clk); rst_n = 1;

        // R1: mode bits without access kind, and access kind without mode bits
        ctl[0] = mk(4'd2, 3'b001, 2'b00, 3'b000, 4'd0); cmpv[0] = 32'h1000;
        apply(1, 32'h1000, 0, 0, 0, 0, 2'd3, 0, 0, 0, "R1 no access bit");
        ctl[0] = mk(4'd2, 3'b000, 2'b00, 3'b100, 4'd0);
        apply(1, 32'h1000, 0, 0, 0, 0, 2'd3, 0, 0, 0, "R1 no mode bit");
        // R2: exact fetch address
        ctl[0] = mk(4'd2, 3'b001, 2'b00, 3'b100, 4'd0);
        apply(1, 32'h1000, 0, 0, 0, 0, 2'd3, 0, 1, 0, "R2 fetch equal");
        apply(1, 32'h1004, 0, 0, 0, 0, 2'd3, 0, 0, 0, "R2 fetch differs");
        apply(0, 32'h1000, 0, 0, 0, 0, 2'd3, 0, 0, 0, "R2 fetch not valid");
        idle();
        // R3: store-only slot
        ctl[1] = mk(4'd2, 3'b001, 2'b00, 3'b010, 4'd3); cmpv[1] = 32'h3000;
        ctl[0] = '0;
        apply(0, 0, 1, 0, 32'h3000, 2'd2, 2'd3, 0, 0, 0, "R3 load ignored by store slot");
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd3, 0, 1, 1, "R3 store hits");
        // R4: privilege enables
        ctl[1] = mk(4'd2, 3'b100, 2'b00, 3'b010, 4'd3);
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd3, 0, 0, 0, "R4 user-only at machine");
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd0, 0, 1, 1, "R4 user-only at user");
        ctl[1] = mk(4'd2, 3'b010, 2'b00, 3'b010, 4'd3);
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd1, 0, 1, 1, "R4 supervisor");
        // R6: legacy suppressed in virt
        ctl[1] = mk(4'd2, 3'b111, 2'b00, 3'b111, 4'd3);
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd0, 1, 0, 0, "R6 legacy virt");
        // R5: extended virtual enables
        ctl[1] = mk(4'd6, 3'b000, 2'b10, 3'b010, 4'd3);
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd0, 1, 1, 1, "R5 virtual user");
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd0, 0, 0, 0, "R5 virtual enable outside virt");
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd1, 1, 0, 0, "R5 virtual supervisor off");
        ctl[1] = mk(4'd6, 3'b111, 2'b11, 3'b010, 4'd3);
        apply(0, 0, 0, 1, 32'h3000, 2'd2, 2'd3, 1, 0, 0, "R5 machine code under virt");
        // R7: unknown layout
        ctl[1] = mk(4'd3, 3'b111, 2'b11, 3'b111, 4'd0);
        apply(1, 32'h3000, 1, 1, 32'h3000, 2'd2, 2'd3, 0, 0, 0, "R7 layout 3");
        clear_slots();
        // R8/R9: window edges
        ctl[2] = mk(4'd2, 3'b001, 2'b00, 3'b001, 4'd0); cmpv[2] = 32'h2000;
        apply(0, 0, 1, 0, 32'h2007, 2'd0, 2'd3, 0, 1, 2, "R8 code0 last byte");
        apply(0, 0, 1, 0, 32'h2008, 2'd0, 2'd3, 0, 0, 0, "R8 code0 past window");
        apply(0, 0, 1, 0, 32'h1FFC, 2'd2, 2'd3, 0, 0, 0, "R9 below window");
        apply(0, 0, 1, 0, 32'h1FFD, 2'd2, 2'd3, 0, 1, 2, "R9 overlap from below");
        ctl[2] = mk(4'd6, 3'b001, 2'b00, 3'b001, 4'd1);
        apply(0, 0, 1, 0, 32'h2001, 2'd0, 2'd3, 0, 0, 0, "R8 one byte miss");
        apply(0, 0, 1, 0, 32'h2000, 2'd0, 2'd3, 0, 1, 2, "R8 one byte hit");
        ctl[2] = mk(4'd6, 3'b001, 2'b00, 3'b001, 4'd3);
        apply(0, 0, 1, 0, 32'h2003, 2'd0, 2'd3, 0, 1, 2, "R8 four byte end");
        apply(0, 0, 1, 0, 32'h2004, 2'd0, 2'd3, 0, 0, 0, "R8 four byte past");
        ctl[2] = mk(4'd6, 3'b001, 2'b00, 3'b001, 4'd9);
        apply(0, 0, 1, 0, 32'h2007, 2'd0, 2'd3, 0, 1, 2, "R8 unsupported code widens");
        // R10: lowest slot wins, then pulse ends
        ctl[1] = mk(4'd2, 3'b001, 2'b00, 3'b100, 4'd0); cmpv[1] = 32'h4000;
        ctl[3] = mk(4'd6, 3'b001, 2'b00, 3'b100, 4'd0); cmpv[3] = 32'h4000;
        apply(1, 32'h4000, 0, 0, 0, 0, 2'd3, 0, 1, 1, "R10 lowest slot");
        idle();

        // Random: R9 R10 and the gating rules together
        for (int it = 0; it < 400; it++) begin
            logic [3:0] tsel;
            logic [XL-1:0] base, a, pc;
            bit fv, ld, st, vt, er;
            logic [1:0] pr, sz;
            int es;
            base = {$urandom_range(0, 15), 8'h00} + 32'h8000;
            for (int s = 0; s < NS; s++) begin
                case ($urandom_range(0, 5))
                    0, 1: tsel = 4'd2;
                    2, 3, 4: tsel = 4'd6;
                    default: tsel = 4'($urandom_range(0, 15));
                endcase
                ctl[s] = mk(tsel, 3'($urandom), 2'($urandom), 3'($urandom), 4'($urandom));
                cmpv[s] = base + 32'($urandom_range(0, 3) * 4);
            end
            fv = $urandom_range(0, 1) == 1;
            pc = base + 32'($urandom_range(0, 4) * 4);
            case ($urandom_range(0, 2))
                0: begin ld = 1; st = 0; end
                1: begin ld = 0; st = 1; end
                default: begin ld = 0; st = 0; end
            endcase
            a = base + 32'($urandom_range(0, 24)) - 32'd8;
            sz = 2'($urandom);
            case ($urandom_range(0, 2)) 0: pr = 2'd0; 1: pr = 2'd1; default: pr = 2'd3; endcase
            vt = $urandom_range(0, 3) == 0;
            er = 0; es = 0;
            for (int s = NS - 1; s >= 0; s--) begin
                if (model_slot(s, fv, pc, ld, st, a, sz, pr, vt)) begin er = 1; es = s; end
            end
            apply(fv, pc, ld, st, a, sz, pr, vt, er, es, "R9 R10 random");
        end
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule